// File: doc/BRIEF.md
# Codec interrupt and paging register

This block is one 16-bit control and status register of an audio codec. It sits at a single index on a simple register bus. It gathers two event sources into one interrupt: a jack sense engine that reports when a sense cycle has finished, and a GPIO change detector. A sticky status flag records that an event happened. A two-bit cause field records why the first event after the last clear occurred. An enable bit decides whether the flag reaches the serial link as an interrupt request.

The same register starts sense cycles. Writing the sense-control bit sends a one-cycle start pulse to the sense engine, and the bit then reads as busy until the engine reports completion. A parameter removes sense support; the bit then stays at zero. The low bits hold a page number that selects which bank of extended registers the rest of the register file shows.

Top module: `cir_irq_page_reg`

## Requirements
- R1: After a synchronous reset the register reads 0000h, and `sense_start`, `link_irq` and `page_sel` are all low.
- R2: Bit 15 is the status flag. Writing 1 to it clears it, unless an event arrives in the same cycle. Writing 0 to it leaves it unchanged.
- R3: A `sense_done` or `gpio_chg` pulse sets bit 15 on the next clock, whatever the value of the enable bit.
- R4: Bits 14:13 hold the cause. When an event arrives while the flag is clear, the cause loads 01 for a completed sense cycle, 10 for a GPIO change, or 11 when both arrive together. Later events keep it unchanged while the flag stays set. Clearing the flag returns the cause to 00.
- R5: If a clear write and an event fall in the same cycle, the flag stays set and the cause loads the code of the new event.
- R6: With sense support, a write of 1 to bit 12 while bit 12 reads 0 raises `sense_start` for exactly the one cycle after the write. Bit 12 then reads 1 until a `sense_done` pulse. A write of 1 while bit 12 reads 1 gives no pulse.
- R7: Without sense support, bit 12 always reads 0 and `sense_start` never rises.
- R8: Bit 11 is a read/write enable. `link_irq` equals the status flag ANDed with the enable, and it follows both in the same cycle that the register shows the new values.
- R9: Bits 3:0 are a read/write page number that drives `page_sel`.
- R10: Bits 10:4 read as 0 and ignore writes.
- R11: Only an access whose address equals `REG_INDEX` has any effect. A read strobe returns the register value on `bus_rdata` in the next cycle, with the value as it was before that clock edge. In any cycle that follows no matching read, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register index of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| sense_done | input | 1 | Sense engine reports a finished cycle (one-cycle pulse) |
| gpio_chg | input | 1 | GPIO input status changed (one-cycle pulse) |
| sense_start | output | 1 | One-cycle start pulse to the sense engine |
| page_sel | output | PAGE_W | Selected extended register page |
| link_irq | output | 1 | Interrupt request for the link GPI slot |

## Verification
The bench builds two copies side by side on the same stimulus. One copy has `SENSE_EN = 1` and the other has `SENSE_EN = 0`. Both use a 7-bit address and a 4-bit page. Every eight-bit input pattern (write, the three control bits, both events, read, address hit or miss) is applied after every other pattern. This covers every single-cycle state transition, including a clear colliding with an event and a start write colliding with completion. The unsupported copy shows whether bit 12 and the start pulse stay quiet under exactly the same traffic.

// File: rtl/cir_pkg.sv
package cir_pkg;
  localparam int REG_W     = 16;
  localparam int FLAG_BIT  = 15;
  localparam int CAUSE_HI  = 14;
  localparam int CAUSE_LO  = 13;
  localparam int SENSE_BIT = 12;
  localparam int EN_BIT    = 11;

  typedef logic [1:0] cause_t;
  localparam cause_t CAUSE_NONE  = 2'b00;
  localparam cause_t CAUSE_SENSE = 2'b01;
  localparam cause_t CAUSE_GPIO  = 2'b10;
endpackage

// File: rtl/cir_status.sv
module cir_status
  import cir_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ev_sense,
  input  logic   ev_gpio,
  input  logic   clr,
  output logic   flag_q,
  output logic   flag_nxt,
  output cause_t cause_q
);
  logic   ev_any;
  cause_t cause_nxt;

  always_comb begin
    ev_any    = ev_sense | ev_gpio;
    flag_nxt  = ev_any | (flag_q & ~clr);
    cause_nxt = cause_q;
    if (ev_any && (!flag_q || clr))
      cause_nxt = (ev_gpio ? CAUSE_GPIO : CAUSE_NONE) | (ev_sense ? CAUSE_SENSE : CAUSE_NONE);
    else if (clr)
      cause_nxt = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      flag_q  <= flag_nxt;
      cause_q <= cause_nxt;
    end
  end

  // R3
  ev_sets_chk: assert property (@(posedge clk) disable iff (rst) ev_any |=> flag_q);
  // R2
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && clr && !ev_any) |=> (!flag_q && cause_q == CAUSE_NONE));
  // R4
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> $stable(cause_q));
  // R4
  cause_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q == (cause_q != CAUSE_NONE));
endmodule

// File: rtl/cir_sense.sv
module cir_sense #(
  parameter bit SENSE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_wr,
  input  logic done,
  output logic busy_q,
  output logic start_q
);
  generate
    if (SENSE_EN) begin : g_sense
      logic fire;
      always_comb fire = start_wr & ~busy_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          busy_q  <= 1'b0;
          start_q <= 1'b0;
        end else begin
          start_q <= fire;
          if (fire)      busy_q <= 1'b1;
          else if (done) busy_q <= 1'b0;
        end
      end

      // R6
      start_new_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |-> (busy_q && !$past(busy_q)));
      // R6
      busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |=> busy_q);
      // R6
      pulse_one_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);
    end else begin : g_nosense
      always_comb begin
        busy_q  = 1'b0;
        start_q = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/cir_ctrl.sv
module cir_ctrl #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              en_wdata,
  input  logic [PAGE_W-1:0] page_wdata,
  output logic              en_q,
  output logic              en_nxt,
  output logic [PAGE_W-1:0] page_q
);
  always_comb en_nxt = wr_hit ? en_wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      page_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (wr_hit) page_q <= page_wdata;
    end
  end

  // R9
  page_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(page_q));
  // R8
  en_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(en_q));
endmodule

// File: rtl/cir_irq_page_reg.sv
module cir_irq_page_reg
  import cir_pkg::*;
#(
  parameter int          ADDR_W    = 7,
  parameter int          PAGE_W    = 4,
  parameter bit          SENSE_EN  = 1'b1,
  parameter logic [6:0]  REG_INDEX = 7'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [15:0]       bus_rdata,
  input  logic              sense_done,
  input  logic              gpio_chg,
  output logic              sense_start,
  output logic [PAGE_W-1:0] page_sel,
  output logic              link_irq
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_INDEX);

  logic        hit, wr_hit, rd_hit, clr, start_wr;
  logic        flag_q, flag_nxt, en_q, en_nxt, busy_q;
  cause_t      cause_q;
  logic [REG_W-1:0] view;

  always_comb begin
    hit      = (bus_addr == HIT_ADDR);
    wr_hit   = bus_wr & hit;
    rd_hit   = bus_rd & hit;
    clr      = wr_hit & bus_wdata[FLAG_BIT];
    start_wr = wr_hit & bus_wdata[SENSE_BIT];
  end

  cir_status u_status (
    .clk(clk), .rst(rst), .ev_sense(sense_done), .ev_gpio(gpio_chg), .clr(clr),
    .flag_q(flag_q), .flag_nxt(flag_nxt), .cause_q(cause_q)
  );

  cir_sense #(.SENSE_EN(SENSE_EN)) u_sense (
    .clk(clk), .rst(rst), .start_wr(start_wr), .done(sense_done),
    .busy_q(busy_q), .start_q(sense_start)
  );

  cir_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .en_wdata(bus_wdata[EN_BIT]),
    .page_wdata(bus_wdata[PAGE_W-1:0]), .en_q(en_q), .en_nxt(en_nxt), .page_q(page_sel)
  );

  always_comb begin
    view                    = '0;
    view[PAGE_W-1:0]        = page_sel;
    view[EN_BIT]            = en_q;
    view[SENSE_BIT]         = busy_q;
    view[CAUSE_HI:CAUSE_LO] = cause_q;
    view[FLAG_BIT]          = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      link_irq  <= 1'b0;
    end else begin
      bus_rdata <= rd_hit ? view : '0;
      link_irq  <= flag_nxt & en_nxt;
    end
  end

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    link_irq == (flag_q && en_q));
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (bus_rdata == '0));
  // R11
  miss_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit && !sense_done && !gpio_chg) |=> ($stable(flag_q) && $stable(en_q)));
endmodule

// File: tb/sim_cir_irq_page_reg.sv
`timescale 1ns/1ps
module sim_cir_irq_page_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  bus_addr = 7'h24;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        sense_done = 1'b0, gpio_chg = 1'b0;
  logic [15:0] rd0, rd1;
  logic        st0, st1, irq0, irq1;
  logic [3:0]  pg0, pg1;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cir_irq_page_reg #(.SENSE_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(rd0), .sense_done(sense_done), .gpio_chg(gpio_chg),
    .sense_start(st0), .page_sel(pg0), .link_irq(irq0));
  cir_irq_page_reg #(.SENSE_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(rd1), .sense_done(sense_done), .gpio_chg(gpio_chg),
    .sense_start(st1), .page_sel(pg1), .link_irq(irq1));

  // reference state per copy: index 0 supported, index 1 unsupported
  bit       m_flag[2], m_busy[2], m_en[2], m_pulse[2];
  bit [1:0] m_cause[2];
  bit [3:0] m_page[2];
  bit [15:0] m_rd[2];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(input bit w, input bit [15:0] wd, input bit r, input bit hit,
                            input bit sd, input bit gc);
    for (int s = 0; s < 2; s++) begin
      bit ev, clr, wh;
      wh = w & hit;
      ev = sd | gc;
      clr = wh & wd[15];
      m_rd[s] = (r & hit) ? {m_flag[s], m_cause[s], m_busy[s], m_en[s], 7'b0, m_page[s]} : 16'h0;
      if (ev && (!m_flag[s] || clr)) m_cause[s] = {gc, sd};
      else if (clr) m_cause[s] = 2'b00;
      m_flag[s] = ev | (m_flag[s] & ~clr);
      m_pulse[s] = (s == 0) && wh && wd[12] && !m_busy[s];
      if (m_pulse[s]) m_busy[s] = 1'b1;
      else if (sd) m_busy[s] = 1'b0;
      if (wh) begin
        m_en[s] = wd[11];
        m_page[s] = wd[3:0];
      end
    end
  endtask

  task automatic cyc(input bit w, input bit [15:0] wd, input bit r, input bit hit,
                     input bit sd, input bit gc);
    @(negedge clk);
    bus_wr = w; bus_wdata = wd; bus_rd = r; bus_addr = hit ? 7'h24 : 7'h25;
    sense_done = sd; gpio_chg = gc;
    @(posedge clk);
    model_step(w, wd, r, hit, sd, gc);
    #1;
    chk("R2 R3 R4 R5 R6 R10 R11 readback u0", rd0, m_rd[0]);
    chk("R7 R10 R11 readback u1", rd1, m_rd[1]);
    chk("R6 start pulse u0", st0, m_pulse[0]);
    chk("R7 no start u1", st1, 0);
    chk("R8 link irq u0", irq0, m_flag[0] & m_en[0]);
    chk("R8 link irq u1", irq1, m_flag[1] & m_en[1]);
    chk("R9 page u0", pg0, m_page[0]);
    chk("R9 page u1", pg1, m_page[1]);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      m_flag[s] = 0; m_busy[s] = 0; m_en[s] = 0; m_pulse[s] = 0; m_cause[s] = 0; m_page[s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    #1;
    chk("R1 reset irq", irq0 | irq1, 0);
    chk("R1 reset start", st0 | st1, 0);
    chk("R1 reset page", {pg0, pg1}, 0);
    cyc(0, 16'h0, 1, 1, 0, 0);
    chk("R1 reset readback", rd0 | rd1, 0);
    // R4 both events together give cause 11; R5 clear plus event keeps flag
    cyc(0, 16'h0, 0, 1, 1, 1);
    cyc(0, 16'h0, 1, 1, 0, 0);
    chk("R4 cause both", rd0[14:13], 2'b11);
    cyc(1, 16'h8000, 0, 1, 0, 1);
    cyc(0, 16'h0, 1, 1, 0, 0);
    chk("R5 clear with event", rd0[15:13], 3'b110);
    // near-exhaustive pair sweep of eight-bit input patterns
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        for (int k = 0; k < 2; k++) begin
          bit [7:0] p;
          bit [15:0] wd;
          p = (k == 0) ? 8'(i) : 8'(j);
          wd = {p[1], 2'b11, p[2], p[3], 7'h7F, 4'(i ^ (j >> 2))};
          cyc(p[0], wd, p[6], !p[7], p[4], p[5]);
        end
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule